// File: doc/BRIEF.md
# Vertical Interval Timing Decoder

This block turns the position reported by a raster counter into the five vertical and mixed timing strobes a monochrome video source needs around each field's vertical interval. It receives the frame line number, the clock slot inside the line (32 slots per line), the field bit and a raster-size select. From these it produces vertical drive, short vertical drive, vertical blanking, mixed blanking and beam blanking, all active high and all registered.

Inside the block the line and slot are folded into one frame position. The second field begins half a line into the line at the half-frame boundary (262 or 312). For that field the block subtracts that starting point, so both fields share one set of window comparators measured from the field's first equalizing pulse. Each window edge sits a fixed number of clocks after the sync edge of its line. The one exception is the end of the field-2 windows, which falls 14 clocks into its line.

Top module: `vint_decoder`

## Requirements
- R1: While `rst_n` is low, all five outputs are 0.
- R2: Every output is registered: its value after a rising clock edge is the decode of the inputs sampled at that edge.
- R3: `vdrive` is 1 for frame positions P = line*32 + slot in field 1 from P=1 up to but excluding P=9*32+2. In field 2 it runs from H*32+17 up to but excluding (H+9)*32+14.
- R4: `vblank` is 1 in field 1 for 1 ≤ P < 21*32+2, and in field 2 for H*32+17 ≤ P < (H+21)*32+14.
- R5: `vdrive_short` is 1 in field 1 for 3*32+2 ≤ P < 6*32+2, and in field 2 for (H+3)*32+18 ≤ P < (H+6)*32+18.
- R6: `mix_blank` is 1 whenever `vblank` would be 1 for the same inputs, and additionally on every line for slots 0 to 5 (6 clocks).
- R7: `beam_blank` is 1 for slots 0 to 3 of every line. It is also 1 inside the serration region, field-relative positions 2*32+16 ≤ F < 7*32, except where F mod 16 = 15. F is P in field 1 and P − (H*32+16) in field 2.
- R8: H is 262 when `mode_625` is 0 and 312 when it is 1. The field-2 windows move with H, and a frame holds 2H+1 lines.
- R9: The field-2 trailing edges of `vdrive` and `vblank` fall at slot 14 of lines H+9 and H+21, not at slot 2 as in field 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-slot clock, 32 per line |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_625 | input | 1 | 0 selects 525-line raster, 1 selects 625-line raster |
| field | input | 1 | 0 for first field, 1 for second field |
| line | input | 10 | Frame line number, 0 to 2H |
| slot | input | 5 | Clock slot within the line, 0 to 31 |
| vdrive | output | 1 | Vertical drive |
| vdrive_short | output | 1 | Short vertical drive |
| vblank | output | 1 | Vertical processing blanking |
| mix_blank | output | 1 | Mixed processing blanking |
| beam_blank | output | 1 | Mixed beam blanking |

## Verification
A reference counter walks every slot of a full frame in 525 mode and then in 625 mode, so each output is compared against a behavioural model on every clock. Both fields are covered, along with every half-line start and clock-14 end. The two modes separate a decoder that hard-codes one half-frame offset from one that follows the select. Comparing field 1 with field 2 exposes any mix-up between the half-line start and the clock-14 trailing edge. Holding in-window inputs while reset is low shows that reset dominates the decode.

// File: rtl/vint_decoder.sv
module vint_decoder #(
  parameter int LINE_W = 10,
  parameter int SLOT_W = 5,
  parameter int HALF_A = 262,
  parameter int HALF_B = 312
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_625,
  input  logic              field,
  input  logic [LINE_W-1:0] line,
  input  logic [SLOT_W-1:0] slot,
  output logic              vdrive,
  output logic              vdrive_short,
  output logic              vblank,
  output logic              mix_blank,
  output logic              beam_blank
);
  localparam int LW   = 1 << SLOT_W;
  localparam int FP_W = LINE_W + SLOT_W;
  localparam int SR_W = SLOT_W - 1;

  localparam logic [FP_W-1:0] WIN_BEG  = FP_W'(1);
  localparam logic [FP_W-1:0] VD_END1  = FP_W'(9 * LW + 2);
  localparam logic [FP_W-1:0] VD_END2  = FP_W'(9 * LW - 2);
  localparam logic [FP_W-1:0] VB_END1  = FP_W'(21 * LW + 2);
  localparam logic [FP_W-1:0] VB_END2  = FP_W'(21 * LW - 2);
  localparam logic [FP_W-1:0] SV_BEG   = FP_W'(3 * LW + 2);
  localparam logic [FP_W-1:0] SV_END   = FP_W'(6 * LW + 2);
  localparam logic [FP_W-1:0] SER_BEG  = FP_W'(2 * LW + LW / 2);
  localparam logic [FP_W-1:0] SER_END  = FP_W'(7 * LW);
  localparam logic [FP_W-1:0] F2_OFS_A = FP_W'(HALF_A * LW + LW / 2);
  localparam logic [FP_W-1:0] F2_OFS_B = FP_W'(HALF_B * LW + LW / 2);
  localparam logic [SLOT_W-1:0] HB_MIX  = SLOT_W'(6);
  localparam logic [SLOT_W-1:0] HB_BEAM = SLOT_W'(4);

  logic [FP_W-1:0] pos, f2_ofs, rel, vd_end, vb_end;
  logic in_vd, in_vb, in_sv, in_ser;

  assign pos    = {line, slot};
  assign f2_ofs = mode_625 ? F2_OFS_B : F2_OFS_A;
  assign rel    = field ? pos - f2_ofs : pos;
  assign vd_end = field ? VD_END2 : VD_END1;
  assign vb_end = field ? VB_END2 : VB_END1;

  assign in_vd  = rel >= WIN_BEG && rel < vd_end;
  assign in_vb  = rel >= WIN_BEG && rel < vb_end;
  assign in_sv  = rel >= SV_BEG && rel < SV_END;
  assign in_ser = rel >= SER_BEG && rel < SER_END && rel[SR_W-1:0] != '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vdrive       <= 1'b0;
      vdrive_short <= 1'b0;
      vblank       <= 1'b0;
      mix_blank    <= 1'b0;
      beam_blank   <= 1'b0;
    end else begin
      vdrive       <= in_vd;
      vdrive_short <= in_sv;
      vblank       <= in_vb;
      mix_blank    <= in_vb || slot < HB_MIX;
      beam_blank   <= in_ser || slot < HB_BEAM;
    end
  end
endmodule

// File: rtl/vint_decoder_chk.sv
module vint_decoder_chk #(
  parameter int SLOT_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [SLOT_W-1:0] slot,
  input logic              vdrive,
  input logic              vdrive_short,
  input logic              vblank,
  input logic              mix_blank,
  input logic              beam_blank
);
  logic started;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) started <= 1'b0;
    else        started <= 1'b1;
  end

  // R5
  short_in_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vdrive_short |-> vdrive);

  // R3
  drive_in_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vdrive |-> vblank);

  // R6
  vblank_mixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vblank |-> mix_blank);

  // R6
  mix_hblank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    started && $past(slot) < SLOT_W'(6) |-> mix_blank);

  // R7
  beam_hblank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    started && $past(slot) < SLOT_W'(4) |-> beam_blank);

  // R1
  always_comb begin
    if (!rst_n) begin
      reset_quiet_chk: assert (!vdrive && !vdrive_short && !vblank && !mix_blank && !beam_blank);
    end
  end
endmodule

bind vint_decoder vint_decoder_chk #(.SLOT_W(SLOT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .slot(slot),
  .vdrive(vdrive), .vdrive_short(vdrive_short), .vblank(vblank),
  .mix_blank(mix_blank), .beam_blank(beam_blank)
);

// File: tb/vint_decoder_test.sv
module vint_decoder_test;
  localparam time PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_625 = 1'b0;
  logic field = 1'b0;
  logic [9:0] line = '0;
  logic [4:0] slot = '0;
  logic vdrive, vdrive_short, vblank, mix_blank, beam_blank;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit have_exp = 0;
  bit e_vd, e_sv, e_vb, e_mb, e_bb;
  bit e_f2;

  always #(PERIOD / 2) clk = ~clk;

  vint_decoder uut (
    .clk(clk), .rst_n(rst_n), .mode_625(mode_625), .field(field),
    .line(line), .slot(slot), .vdrive(vdrive), .vdrive_short(vdrive_short),
    .vblank(vblank), .mix_blank(mix_blank), .beam_blank(beam_blank)
  );

  task automatic cmp(input string req, input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at line %0d slot %0d mode %0d: actual %0b expected %0b",
               req, line, slot, mode_625, act, exp);
    end
  endtask

  // behavioural model of R3..R8 for one input set
  task automatic model(input bit m, input int l, input int s);
    int h, p, s2;
    bit f2, ser;
    h  = m ? 312 : 262;
    p  = l * 32 + s;
    s2 = h * 32 + 16;
    f2 = p >= s2;
    if (!f2) begin
      e_vd = p >= 1 && p < 9 * 32 + 2;
      e_vb = p >= 1 && p < 21 * 32 + 2;
      e_sv = p >= 3 * 32 + 2 && p < 6 * 32 + 2;
      ser  = p >= 2 * 32 + 16 && p < 7 * 32;
    end else begin
      e_vd = p >= s2 + 1 && p < (h + 9) * 32 + 14;
      e_vb = p >= s2 + 1 && p < (h + 21) * 32 + 14;
      e_sv = p >= (h + 3) * 32 + 18 && p < (h + 6) * 32 + 18;
      ser  = p >= (h + 3) * 32 && p < (h + 7) * 32 + 16;
    end
    ser  = ser && (p % 16) != 15;
    e_mb = e_vb || s < 6;
    e_bb = ser || s < 4;
    e_f2 = f2;
  endtask

  // R2: outputs seen at a falling edge reflect inputs driven one edge earlier
  task automatic step(input bit m, input int l, input int s);
    @(negedge clk);
    if (have_exp) begin
      cmp(e_f2 ? "R2 R3 R8 R9 vdrive" : "R2 R3 vdrive", vdrive, e_vd);
      cmp(e_f2 ? "R2 R4 R8 R9 vblank" : "R2 R4 vblank", vblank, e_vb);
      cmp(e_f2 ? "R2 R5 R8 vdrive_short" : "R2 R5 vdrive_short", vdrive_short, e_sv);
      cmp("R2 R6 mix_blank", mix_blank, e_mb);
      cmp("R2 R7 beam_blank", beam_blank, e_bb);
    end
    model(m, l, s);
    mode_625 = m;
    line = 10'(l);
    slot = 5'(s);
    field = e_f2;
    have_exp = 1;
  endtask

  initial begin
    mode_625 = 1'b0;
    line = 10'd4;
    slot = 5'd1;
    field = 1'b0;
    repeat (3) begin
      @(negedge clk);
      cmp("R1 vdrive", vdrive, 1'b0);
      cmp("R1 vdrive_short", vdrive_short, 1'b0);
      cmp("R1 vblank", vblank, 1'b0);
      cmp("R1 mix_blank", mix_blank, 1'b0);
      cmp("R1 beam_blank", beam_blank, 1'b0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    model(1'b0, 4, 1);
    have_exp = 1;
    for (int m = 0; m < 2; m++) begin
      for (int l = 0; l <= 2 * (m ? 312 : 262); l++) begin
        for (int s = 0; s < 32; s++) step(m[0], l, s);
      end
    end
    step(1'b0, 0, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog expired: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule